// File: doc/BRIEF.md
# Single-Cycle Write-After-Read Sequencer

This block turns one external memory cycle into a sequence of timed strobes so that a narrow 16-bit write can be made to a wide 128-bit row without disturbing the other words of that row. The external cycle is modelled as a fixed number of fast ticks. The sequencer first raises a read strobe while a holding register captures the whole addressed row. It then leaves one idle tick. After that it raises a write strobe that stores the row back, with the selected 16-bit word replaced by the new input data. A read request uses only the read phase. At its end, the addressed word is moved to the 16-bit data output.

A 3-bit timing mode is taken when the cycle starts and sets where the cycle is split. Each step of the mode adds a fixed number of ticks to the read phase, and the write phase loses the same number. The read phase is clamped so that a write always keeps at least one tick. The row storage is a behavioural register array. A new request may be accepted on the final tick of the current cycle, so cycles can run back to back.

Top module: `war_seq`

## Requirements
- R1: After a request is accepted, the read strobe is high from the first tick of the cycle for S = min((mode+1)*STEP, TICKS-2) ticks. The defaults are TICKS=32 and STEP=4.
- R2: In a write cycle, the read strobe is followed by exactly one tick with both strobes low. The write strobe is then high for the remaining TICKS-1-S ticks, up to the end of the cycle.
- R3: The read strobe and the write strobe are never high in the same tick.
- R4: The holding-register load pulse is high in exactly the ticks in which the read strobe is high.
- R5: While the write strobe is high, the write-back row equals the captured row with word w replaced by the input data. Word w occupies bits [16w+15:16w].
- R6: After a write, a later read of any other word of the same row returns its earlier value.
- R7: A read cycle raises no write strobe. After the read phase, the data output holds word w of the addressed row.
- R8: During a write cycle the data output keeps the value it had before the cycle.
- R9: The mode, row, word select, operation and data are sampled only on the tick that accepts the request. Changes to them later in the cycle have no effect.
- R10: Mode 7 is clamped to a 30-tick read phase. A write cycle in mode 7 therefore keeps a one-tick write strobe.
- R11: A request presented on the final tick of a busy cycle is accepted at once, and the next cycle begins on the following tick.
- R12: After reset, both strobes, the load pulse and busy are low, the data output is zero, and every row reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request; accepted when idle or on the final tick |
| op_wr | input | 1 | 1 = write-after-read, 0 = read |
| mode | input | 3 | Split-point timing mode |
| row_sel | input | 3 | Row address |
| word_sel | input | 3 | Word within the row |
| din | input | 16 | Write data word |
| busy | output | 1 | A cycle is in progress |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| hold_ld | output | 1 | Holding-register load pulse |
| wr_row | output | 128 | Merged row driven during the write phase |
| dout | output | 16 | Data output word |

## Verification
The bound checker watches every tick for the following:
- the two strobes never overlap;
- a cycle always opens with a read strobe;
- a falling read strobe is never met by a write strobe, and a rising write strobe never directly follows a high read strobe;
- the write-back row stays stable within a write phase;
- the data output stays still while writing.

Only the bench scenarios can show the rest. These are the exact phase widths for each of the eight modes, including the clamp, and the word merge against an independent row model. They also cover the preservation of unselected words as seen through later reads, the ignoring of inputs that change mid-cycle, and back-to-back acceptance.

// File: rtl/war_pkg.sv
package war_pkg;

  // Length of the read phase in ticks; the write phase keeps at least one tick
  // and one gap tick always separates the two strobes.
  function automatic int read_span(int mode, int step, int ticks);
    int span;
    span = (mode + 1) * step;
    if (span > ticks - 2) span = ticks - 2;
    return span;
  endfunction

endpackage

// File: rtl/war_timer.sv
module war_timer #(
  parameter int TICKS  = 32,
  parameter int STEP   = 4,
  parameter int MODE_W = 3,
  localparam int CW    = $clog2(TICKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_wr_q,
  input  logic [MODE_W-1:0] mode,
  output logic              accept,
  output logic              busy,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              gap_tick
);
  import war_pkg::*;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] span_q;
  logic          last_tick;

  assign last_tick = busy && (cnt_q == CW'(TICKS - 1));
  assign accept    = start && (!busy || last_tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
      span_q <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      cnt_q  <= '0;
      span_q <= CW'(read_span(int'(mode), STEP, TICKS));
    end else if (last_tick) begin
      busy   <= 1'b0;
      cnt_q  <= '0;
    end else if (busy) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign rd_stb   = busy && (cnt_q < span_q);
  assign gap_tick = busy && (cnt_q == span_q);
  assign wr_stb   = busy && op_wr_q && (cnt_q > span_q);

endmodule

// File: rtl/war_merge.sv
module war_merge #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 8,
  localparam int SEL_W = $clog2(WORDS),
  localparam int ROW_W = WORD_W * WORDS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] row_in,
  input  logic [SEL_W-1:0] sel,
  input  logic [WORD_W-1:0] din,
  output logic [ROW_W-1:0] hold_q,
  output logic [ROW_W-1:0] merged
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    hold_q <= '0;
    else if (load) hold_q <= row_in;
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign merged[w*WORD_W +: WORD_W] =
      (sel == SEL_W'(w)) ? din : hold_q[w*WORD_W +: WORD_W];
  end

endmodule

// File: rtl/war_rows.sv
module war_rows #(
  parameter int ROWS   = 8,
  parameter int ROW_W  = 128,
  localparam int ROW_AW = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ROW_AW-1:0] row,
  input  logic [ROW_W-1:0]  wdata,
  output logic [ROW_W-1:0]  rdata
);

  logic [ROW_W-1:0] rows_q [ROWS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++) rows_q[r] <= '0;
    end else if (we) begin
      rows_q[row] <= wdata;
    end
  end

  assign rdata = rows_q[row];

endmodule

// File: rtl/war_seq.sv
module war_seq #(
  parameter int WORD_W  = 16,
  parameter int WORDS   = 8,
  parameter int ROWS    = 8,
  parameter int TICKS   = 32,
  parameter int STEP    = 4,
  parameter int MODE_W  = 3,
  localparam int SEL_W  = $clog2(WORDS),
  localparam int ROW_AW = $clog2(ROWS),
  localparam int ROW_W  = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_wr,
  input  logic [MODE_W-1:0] mode,
  input  logic [ROW_AW-1:0] row_sel,
  input  logic [SEL_W-1:0]  word_sel,
  input  logic [WORD_W-1:0] din,
  output logic              busy,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              hold_ld,
  output logic [ROW_W-1:0]  wr_row,
  output logic [WORD_W-1:0] dout
);

  logic              accept;
  logic              gap_tick;
  logic              op_wr_q;
  logic [ROW_AW-1:0] row_q;
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] din_q;
  logic [ROW_W-1:0]  row_rd;
  logic [ROW_W-1:0]  hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_wr_q <= 1'b0;
      row_q   <= '0;
      sel_q   <= '0;
      din_q   <= '0;
    end else if (accept) begin
      op_wr_q <= op_wr;
      row_q   <= row_sel;
      sel_q   <= word_sel;
      din_q   <= din;
    end
  end

  war_timer #(.TICKS(TICKS), .STEP(STEP), .MODE_W(MODE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .op_wr_q  (op_wr_q),
    .mode     (mode),
    .accept   (accept),
    .busy     (busy),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .gap_tick (gap_tick)
  );

  assign hold_ld = rd_stb;

  war_rows #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_stb),
    .row   (row_q),
    .wdata (wr_row),
    .rdata (row_rd)
  );

  war_merge #(.WORD_W(WORD_W), .WORDS(WORDS)) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (hold_ld),
    .row_in (row_rd),
    .sel    (sel_q),
    .din    (din_q),
    .hold_q (hold_q),
    .merged (wr_row)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   dout <= '0;
    else if (gap_tick && !op_wr_q) dout <= hold_q[int'(sel_q)*WORD_W +: WORD_W];
  end

endmodule

// File: rtl/war_seq_chk.sv
module war_seq_chk #(
  parameter int ROW_W  = 128,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [ROW_W-1:0]  wr_row,
  input logic [WORD_W-1:0] dout
);

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  // R1
  read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> rd_stb);

  // R2
  gap_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_stb) |-> !wr_stb);

  // R2
  write_not_adjacent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_stb) |-> !$past(rd_stb));

  // R5
  wr_row_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && $past(wr_stb)) |-> $stable(wr_row));

  // R8
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $stable(dout));

endmodule

bind war_seq war_seq_chk #(.ROW_W(ROW_W), .WORD_W(WORD_W)) u_war_seq_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .rd_stb (rd_stb),
  .wr_stb (wr_stb),
  .wr_row (wr_row),
  .dout   (dout)
);

// File: tb/test_war_seq.sv
module test_war_seq;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         op_wr = 1'b0;
  logic [2:0]   mode = '0;
  logic [2:0]   row_sel = '0;
  logic [2:0]   word_sel = '0;
  logic [15:0]  din = '0;
  logic         busy, rd_stb, wr_stb, hold_ld;
  logic [127:0] wr_row;
  logic [15:0]  dout;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  war_seq i_war_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_wr(op_wr), .mode(mode),
    .row_sel(row_sel), .word_sel(word_sel), .din(din), .busy(busy),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .hold_ld(hold_ld), .wr_row(wr_row),
    .dout(dout)
  );

  typedef struct {
    bit           wr;
    int           rd_w;
    int           wr_w;
    logic [127:0] row;
    logic [15:0]  dout;
  } exp_t;

  exp_t         exp_q[$];
  logic [127:0] model [8];
  logic [15:0]  last_dout = '0;

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Driver: called just after a falling edge; returns on the final tick of the cycle.
  task automatic do_op(bit wr, int m, int r, int w, logic [15:0] d);
    exp_t e;
    int   span;
    span = 4 * m + 4;
    if (span > 30) span = 30;
    e.wr   = wr;
    e.rd_w = span;
    e.wr_w = wr ? (32 - span - 1) : 0;
    if (wr) begin
      e.row = model[r];
      e.row[w*16 +: 16] = d;
      model[r] = e.row;
      e.dout = last_dout;
    end else begin
      e.row = '0;
      e.dout = model[r][w*16 +: 16];
      last_dout = e.dout;
    end
    exp_q.push_back(e);
    start = 1'b1; op_wr = wr; mode = 3'(m); row_sel = 3'(r); word_sel = 3'(w); din = d;
    @(negedge clk);
    // R9: scramble every request field once the request has been taken
    start = 1'b0; op_wr = ~wr; mode = ~3'(m); row_sel = ~3'(r); word_sel = ~3'(w); din = ~d;
    repeat (31) @(negedge clk);
  endtask

  // Monitor
  bit   active = 0;
  bit   rd_prev = 0;
  bit   busy_prev = 0;
  int   rd_cnt, wr_cnt, b2b_seen = 0, overlap = 0, ld_bad = 0;
  bit   row_bad;
  logic [127:0] row_seen;
  exp_t cur;

  task automatic finish_op();
    chk(rd_cnt == cur.rd_w, "R1 R10", "read strobe width", 128'(rd_cnt), 128'(cur.rd_w));
    chk(wr_cnt == cur.wr_w, cur.wr ? "R2 R10" : "R7", "write strobe width", 128'(wr_cnt), 128'(cur.wr_w));
    chk(dout == cur.dout, cur.wr ? "R8" : "R7 R6 R9", "data output", 128'(dout), 128'(cur.dout));
    if (cur.wr)
      chk(!row_bad, "R5 R9", "write-back row", row_seen, cur.row);
    active = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_stb && !rd_prev) begin
        if (active) finish_op();
        if (busy_prev) b2b_seen++;
        if (exp_q.size() == 0) begin
          chk(0, "R1", "unexpected cycle", 0, 1);
        end else begin
          cur = exp_q.pop_front();
          active = 1; rd_cnt = 0; wr_cnt = 0; row_bad = 0; row_seen = '0;
        end
      end
      if (rd_stb && wr_stb) overlap++;
      if (hold_ld != rd_stb) ld_bad++;
      if (active) begin
        if (rd_stb) rd_cnt++;
        if (wr_stb) begin
          wr_cnt++;
          if (wr_row !== cur.row) begin row_bad = 1; row_seen = wr_row; end
        end
        if (!busy) finish_op();
      end
      rd_prev = rd_stb;
      busy_prev = busy;
    end
  end

  initial begin
    #(4 * 150000);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int r = 0; r < 8; r++) model[r] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12: reset state
    chk(!rd_stb && !wr_stb && !hold_ld && !busy, "R12", "strobes after reset",
        128'({rd_stb, wr_stb, hold_ld, busy}), 0);
    chk(dout == 16'h0, "R12", "dout after reset", 128'(dout), 0);
    // R12: unwritten row reads zero
    do_op(0, 0, 2, 5, 16'h0);
    @(negedge clk);
    // Writes in all eight modes, back to back (R11), then read back (R6)
    for (int m = 0; m < 8; m++) do_op(1, m, 3, m, 16'hA000 + 16'(m * 16'h111));
    repeat (3) @(negedge clk);
    for (int w = 0; w < 8; w++) do_op(0, 7 - w, 3, w, 16'h0);
    repeat (2) @(negedge clk);
    // Overwrite a single word and confirm neighbours survive (R6)
    do_op(0, 1, 3, 4, 16'h0);
    do_op(1, 2, 3, 4, 16'h5A5A);
    do_op(1, 7, 6, 0, 16'hFFFF);
    repeat (2) @(negedge clk);
    do_op(0, 3, 3, 3, 16'h0);
    do_op(0, 0, 3, 4, 16'h0);
    do_op(0, 5, 3, 5, 16'h0);
    do_op(0, 7, 6, 0, 16'h0);
    do_op(0, 6, 6, 1, 16'h0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && !active, "R1", "all cycles observed", 128'(exp_q.size()), 0);
    chk(overlap == 0, "R3", "strobe overlap ticks", 128'(overlap), 0);
    chk(ld_bad == 0, "R4", "load pulse mismatch ticks", 128'(ld_bad), 0);
    chk(b2b_seen > 0, "R11", "back-to-back cycles", 128'(b2b_seen), 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule